// File: doc/BRIEF.md
# Fractional-Prescaler Baud Tick Generator

This block derives the 16x oversampling tick that a serial receiver and transmitter need from the system clock. Two dividers are cascaded. The first is a prescaler whose factor P can be any value from 1 to 16 in steps of one half. The second is an integer divider whose factor N is programmed as N-1. The block emits `tick_o`, a single-cycle pulse at 16 times the bit rate. It also emits `bit_o`, a strobe that marks every sixteenth tick.

The prescaler works as a phase accumulator. It adds 2 on every enabled clock and fires when the running sum reaches 2P. It keeps the remainder, so a half-integer factor such as 6.5 gives prescaler periods that alternate between 7 and 6 clocks. The result is a tick rate of Fref / (N·P), where Fref is the block clock. When the block is clocked at twice an oscillator frequency F, the bit rate is 2F / (16·N·P). For example, a 5 MHz oscillator with P = 6.5 and N = 5 gives 19230.77 baud, which is 0.16 % above 19200.

Settings are taken up only at tick boundaries. A new prescaler code or divisor waits for the next `tick_o` and then restarts all counters from zero. This prevents a setting change from producing a short or torn period.

Top module: `baud_gen`

## Requirements
- R1: While `rst_ni` is low, `tick_o` and `bit_o` are low and every counter is zero. After release, the first tick comes only after one full period.
- R2: A divisor value D on `div_i` divides the prescaler ticks by D+1. With P = 1 and D = 4, `tick_o` pulses every 5 clocks.
- R3: A prescaler code k in 1..31 selects P = (k+1)/2, so code 12 selects 6.5. The prescaler period is P clocks when P is an integer. For a half-integer P, the period alternates between ceil(P) and floor(P), and the longer period comes first after a restart.
- R4: `tick_o` is high for one cycle at a time. Its spacing is N·P clocks on average. With code 12 and D = 4, the spacings alternate 33, 32, 33, and so on.
- R5: A prescaler code of 0 turns the generator off, and neither output ever pulses.
- R6: While `en_i` is low, both outputs stay low and all counters are held at zero. After `en_i` rises, the first tick comes one full period later.
- R7: `bit_o` pulses in the same cycle as every sixteenth `tick_o`, counted from a restart, and at no other time.
- R8: A change on `presc_i` or `div_i` takes effect after the next `tick_o`. That tick is still produced with the old setting. All counters then restart from zero with the new setting.
- R9: With code 12 and D = 4, `bit_o` pulses are exactly 520 clocks apart. At a 10 MHz block clock, this gives 19230.77 baud, 0.16 % above 19200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears the counters |
| presc_i | input | 5 | Prescaler code; P = (code+1)/2, 0 = off |
| div_i | input | 8 | Integer divisor written as N-1 |
| tick_o | output | 1 | One-cycle pulse at 16x the bit rate |
| bit_o | output | 1 | One-cycle pulse on every 16th tick |

## Verification
The hardest case to reach is a setting change while a period is partly done. The bench has to show that the new value waits for the tick boundary, that this tick keeps the old spacing, and that the following spacing starts cleanly from zero. To get there, the bench runs a long period, waits a few cycles past a tick, and then writes a much shorter divisor. It measures the gap that ends the old period and the gap that follows under the new setting. Half-integer prescaling is covered by recording successive tick spacings for code 12. A behavioural model, compared on every clock, catches any drift in the carried remainder.

// File: rtl/baud_pkg.sv
`timescale 1ns/1ps
package baud_pkg;
  localparam int unsigned CODE_W = 5;
  localparam int unsigned DIV_W  = 8;
  localparam int unsigned OVS    = 16;
  // accumulator must hold 2P_max + 1 = 33
  localparam int unsigned ACC_W  = CODE_W + 1;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [DIV_W-1:0]  div_t;

  typedef struct packed {
    code_t code;
    div_t  div;
  } cfg_t;
endpackage

// File: rtl/baud_presc.sv
`timescale 1ns/1ps
module baud_presc #(
  parameter int unsigned CODE_W = 5,
  localparam int unsigned ACC_W = CODE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              ptick_o,
  output logic [ACC_W-1:0]  acc_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] thr;

  // threshold is 2P = code + 1
  assign thr     = ACC_W'(code_i) + ACC_W'(1);
  assign sum     = acc_q + ACC_W'(2);
  assign ptick_o = run_i && (sum >= thr);
  assign acc_o   = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clr_i)   acc_q <= '0;
    else if (run_i)   acc_q <= (sum >= thr) ? sum - thr : sum;
  end
endmodule

// File: rtl/baud_ndiv.sv
`timescale 1ns/1ps
module baud_ndiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic [DIV_W-1:0] cnt_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == div_i);
  assign tick_o = tick_i && wrap;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= wrap ? '0 : cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/baud_bitdiv.sv
`timescale 1ns/1ps
module baud_bitdiv #(
  parameter int unsigned OVS = 16,
  localparam int unsigned CW = (OVS > 1) ? $clog2(OVS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic bit_o
);
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last  = (cnt_q == CW'(OVS - 1));
  assign bit_o = tick_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= last ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/baud_gen.sv
`timescale 1ns/1ps
module baud_gen
  import baud_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CODE_W-1:0] presc_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              tick_o,
  output logic              bit_o
);
  cfg_t             act_q;
  logic             run;
  logic             ptick;
  logic             otick;
  logic             bstb;
  logic             cfg_diff;
  logic             reload;
  logic [ACC_W-1:0] acc;
  logic [DIV_W-1:0] cnt;

  assign run      = en_i && (act_q.code != '0);
  assign cfg_diff = (presc_i != act_q.code) || (div_i != act_q.div);
  // idle paths load immediately; running path waits for a tick boundary
  assign reload   = !en_i || (act_q.code == '0) || (otick && cfg_diff);

  baud_presc #(.CODE_W(CODE_W)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (reload),
    .run_i   (run),
    .code_i  (act_q.code),
    .ptick_o (ptick),
    .acc_o   (acc)
  );

  baud_ndiv #(.DIV_W(DIV_W)) u_ndiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (reload),
    .tick_i (ptick),
    .div_i  (act_q.div),
    .tick_o (otick),
    .cnt_o  (cnt)
  );

  baud_bitdiv #(.OVS(OVS)) u_bit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (reload),
    .tick_i (otick),
    .bit_o  (bstb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      tick_o <= 1'b0;
      bit_o  <= 1'b0;
    end else begin
      tick_o <= otick;
      bit_o  <= bstb;
      if (reload) begin
        act_q.code <= presc_i;
        act_q.div  <= div_i;
      end
    end
  end
endmodule

// File: rtl/baud_gen_chk.sv
`timescale 1ns/1ps
module baud_gen_chk
  import baud_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              tick_o,
  input logic              bit_o,
  input cfg_t              act_q,
  input logic [ACC_W-1:0]  acc,
  input logic [DIV_W-1:0]  cnt,
  input logic              otick,
  input logic              cfg_diff
);
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!tick_o && !bit_o));

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= act_q.div);

  p_acc_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q.code != '0) |-> (acc <= ACC_W'(act_q.code)));

  p_off_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q.code == '0) |=> !tick_o);

  p_dis_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!tick_o && !bit_o));

  p_dis_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (acc == '0 && cnt == '0));

  p_bit_on_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_o |-> tick_o);

  p_cfg_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && otick && cfg_diff) |=> (acc == '0 && cnt == '0));
endmodule

bind baud_gen baud_gen_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .tick_o   (tick_o),
  .bit_o    (bit_o),
  .act_q    (act_q),
  .acc      (acc),
  .cnt      (cnt),
  .otick    (otick),
  .cfg_diff (cfg_diff)
);

// File: tb/sim_baud_gen.sv
`timescale 1ns/1ps
module sim_baud_gen;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en = 1'b0;
  logic [4:0] presc = '0;
  logic [7:0] div = '0;
  logic       tick_o, bit_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  baud_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en),
    .presc_i(presc), .div_i(div), .tick_o(tick_o), .bit_o(bit_o)
  );

  // behavioural reference: integers only
  int  m_acc, m_cnt, m_bcnt, m_code, m_div;
  bit  exp_tick, exp_bit;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_acc = 0; m_cnt = 0; m_bcnt = 0; m_code = 0; m_div = 0;
      exp_tick = 0; exp_bit = 0;
    end else begin
      bit run, pt, ot, bt, ld;
      int s;
      run = en && (m_code != 0);
      s   = m_acc + 2;
      pt  = run && (s >= m_code + 1);
      ot  = pt && (m_cnt == m_div);
      bt  = ot && (m_bcnt == 15);
      ld  = !en || (m_code == 0) || (ot && (int'(presc) != m_code || int'(div) != m_div));
      exp_tick = ot;
      exp_bit  = bt;
      if (ld) begin
        m_acc = 0; m_cnt = 0; m_bcnt = 0;
        m_code = int'(presc); m_div = int'(div);
      end else begin
        if (run) m_acc = pt ? s - (m_code + 1) : s;
        if (pt)  m_cnt = (m_cnt == m_div) ? 0 : m_cnt + 1;
        if (ot)  m_bcnt = (m_bcnt + 1) % 16;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      checks++;
      if (tick_o !== exp_tick || bit_o !== exp_bit) begin
        errors++;
        $display("FAIL R4/model: tick=%0b bit=%0b expected tick=%0b bit=%0b at %0t",
                 tick_o, bit_o, exp_tick, exp_bit, $time);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic gap_tick(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!tick_o && g < 5000);
  endtask

  task automatic gap_bit(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!bit_o && g < 20000);
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (tick_o || bit_o) c++; end
  endtask

  task automatic setup(input int code, input int d);
    @(negedge clk);
    en = 0; presc = 5'(code); div = 8'(d);
    @(negedge clk);
    en = 1;
  endtask

  initial begin
    int g, c;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 tick in reset", int'(tick_o), 0);
    check("R1 bit in reset", int'(bit_o), 0);
    rst_ni = 1;

    // R2: P=1, D=4 -> every 5 clocks; first after full period (R1/R6)
    setup(1, 4);
    gap_tick(g); check("R6 first gap after enable", g, 5);
    for (int i = 0; i < 3; i++) begin gap_tick(g); check("R2 divide by D+1", g, 5); end

    // R3: P=6.5, N=1 -> 7,6,7,6
    setup(12, 0);
    for (int i = 0; i < 4; i++) begin
      gap_tick(g); check("R3 half-step period", g, (i % 2 == 0) ? 7 : 6);
    end
    // R3 integer P=3 (code 5)
    setup(5, 0);
    for (int i = 0; i < 3; i++) begin gap_tick(g); check("R3 integer period", g, 3); end

    // R4/R7/R9: P=6.5, N=5
    setup(12, 4);
    for (int i = 0; i < 4; i++) begin
      gap_tick(g); check("R4 tick spacing", g, (i % 2 == 0) ? 33 : 32);
    end
    setup(12, 4);
    gap_bit(g); check("R7 first bit strobe", g, 520);
    gap_bit(g); check("R9 bit period 520", g, 520);
    check("R9 baud x100 at 10MHz", int'(1.0e9 / real'(g)), 1923077);

    // R5: code 0 -> silent
    setup(0, 0);
    count_ticks(300, c); check("R5 off no ticks", c, 0);

    // R6: enable low -> silent
    setup(1, 0);
    @(negedge clk); en = 0;
    count_ticks(200, c); check("R6 disabled no ticks", c, 0);

    // R8: change mid-period, P=2 (code 3), D=9 -> 20 clocks
    setup(3, 9);
    gap_tick(g); check("R8 old period", g, 20);
    repeat (5) @(negedge clk);
    div = 8'd1;
    gap_tick(g); check("R8 boundary tick keeps old", g, 15);
    gap_tick(g); check("R8 new period after restart", g, 4);
    gap_tick(g); check("R8 new period steady", g, 4);

    // R1 reset mid-run clears outputs
    rst_ni = 0;
    @(negedge clk);
    check("R1 reset mid-run", int'(tick_o | bit_o), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule